// File: doc/BRIEF.md
# Receive Buffer Descriptor Sequencer

This block takes bytes from a serial receiver front end and places them into a ring of receive buffers. Each buffer is described by an entry in a small internal descriptor table that holds a ready flag, a last-entry flag and the buffer's start address. For every byte it accepts, the block issues one memory write with the address and the data. A buffer is closed when it holds the programmed maximum number of bytes, when the byte that ends a frame arrives, or when an error is flagged. On close the block reports the byte count and the status through a one-cycle completion pulse, marks the descriptor as used, and moves to the next descriptor.

A host configures three values through a 16-bit configuration port: the buffer length limit, the ring base index and the current descriptor index. The host also loads descriptors through a separate port. The length limit is copied into a private down-counter only when a buffer opens, so a change made while a buffer is in use takes effect only from the next buffer. When the sequencer reaches a descriptor that the host has not yet handed back, it raises a busy flag and drops bytes until a ready descriptor appears.

Top module: `rxbd_seq`

## Requirements
- R1: Each accepted byte produces one memory write one clock after it is accepted. The first byte of a buffer goes to the descriptor's start address, and each later byte goes to the previous address plus one.
- R2: A buffer closes on the write that brings its byte count to the length limit latched when it opened. The completion pulse carries that count.
- R3: No buffer ever receives more bytes than its latched length limit. The next byte goes to the next descriptor.
- R4: A byte marked end-of-frame is written and closes the buffer early. The completion reports the frame-end status bit with done_err low.
- R5: A byte marked as an error is not written. It closes the open buffer, and the completion reports the error status bit with done_frame low and the count of bytes written before it. If no buffer is open, such a byte is ignored.
- R6: A length limit written while a buffer is open does not change that buffer's limit.
- R7: The length limit is written with cfg_sel=0. The write is ignored if the value is zero, or if bits [1:0] are nonzero while fifo8_mode is low. Any nonzero value is accepted while fifo8_mode is high. The reset value is 64.
- R8: After closing a descriptor, the current index advances by one. It reloads from the base index (cfg_sel=1, reset 0) if that descriptor has its wrap flag set or is the last table entry. After reset the current index is 0.
- R9: A write to the current index (cfg_sel=2) is accepted when rx_en is low, or when no buffer is open and no byte is accepted in the same cycle. Otherwise it is ignored. Writes to the index or the base with a value of NUM_BD or more are ignored.
- R10: A byte that arrives with no buffer open, while the current descriptor is not ready, is dropped and sets busy. Busy clears when a buffer opens.
- R11: While rx_en is low, incoming bytes are ignored and no write occurs.
- R12: On close, done pulses for one cycle together with the last write, and done_idx names the closed descriptor. That descriptor is no longer ready until the host loads it again through bd_we, which also sets its ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, one full 16-bit word per cycle |
| cfg_sel | input | 2 | 0 length limit, 1 base index, 2 current index |
| cfg_wdata | input | 16 | Configuration write data |
| fifo8_mode | input | 1 | Byte-wide receive path, lifts the multiple-of-4 rule |
| bd_we | input | 1 | Descriptor load strobe, sets the ready flag |
| bd_idx | input | IDX_W | Descriptor index to load |
| bd_wrap | input | 1 | Wrap flag of the loaded descriptor |
| bd_addr | input | 16 | Buffer start address of the loaded descriptor |
| rx_en | input | 1 | Receiver enable |
| rx_valid | input | 1 | Byte strobe from the front end |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Byte is the last byte of a frame |
| rx_err | input | 1 | Error flagged with this strobe |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 16 | Buffer memory write address |
| mem_data | output | 8 | Buffer memory write data |
| done | output | 1 | Buffer closed pulse |
| done_idx | output | IDX_W | Index of the closed descriptor |
| done_len | output | 16 | Bytes written into the closed buffer |
| done_frame | output | 1 | Closed by end-of-frame |
| done_err | output | 1 | Closed by error |
| busy | output | 1 | Bytes being dropped for lack of a ready descriptor |
| cur_ptr | output | IDX_W | Current descriptor index |

## Verification
A byte presented before a rising edge shows up as a memory write, and possibly a completion, on that same edge. It is therefore visible at the following falling edge. The busy flag and the current index update on that edge too. The driver applies each byte or configuration word at a falling edge and records the expected writes and completions in queues. The monitor compares them at every falling edge, so each result is checked exactly one cycle after its stimulus. Direct checks on busy, cur_ptr and the completion fields are taken at the falling edge after the stimulus, which is the first point where those registered values are settled.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int LEN_W  = 16;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_LEN  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_PTR  = 2'd2
  } cfg_sel_e;

  typedef struct packed {
    logic              ready;
    logic              wrap;
    logic [ADDR_W-1:0] addr;
  } bd_t;
endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg
  import rxbd_pkg::*;
#(
  parameter int             NUM_BD  = 8,
  parameter int             IDX_W   = 3,
  parameter logic [LEN_W-1:0] RST_LEN = 16'd64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [LEN_W-1:0] cfg_wdata,
  input  logic             fifo8_mode,
  output logic [LEN_W-1:0] max_len,
  output logic [IDX_W-1:0] base_idx,
  output logic             ptr_req,
  output logic [IDX_W-1:0] ptr_val
);
  logic len_ok, idx_ok, len_en, base_en;

  always_comb begin
    len_ok  = (cfg_wdata != '0) && (fifo8_mode || (cfg_wdata[1:0] == 2'b00));
    idx_ok  = cfg_wdata < LEN_W'(NUM_BD);
    len_en  = cfg_we && (cfg_sel == SEL_LEN) && len_ok;
    base_en = cfg_we && (cfg_sel == SEL_BASE) && idx_ok;
    ptr_req = cfg_we && (cfg_sel == SEL_PTR) && idx_ok;
    ptr_val = cfg_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_len  <= RST_LEN;
      base_idx <= '0;
    end else begin
      if (len_en)  max_len  <= cfg_wdata;
      if (base_en) base_idx <= cfg_wdata[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/rxbd_bdmem.sv
module rxbd_bdmem
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              host_wrap,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output bd_t               rd_bd
);
  bd_t table_v [NUM_BD];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_entry
    bd_t ent_q, ent_d;
    logic ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (host_we && (host_idx == IDX_W'(g))) begin
        ent_d  = '{ready: 1'b1, wrap: host_wrap, addr: host_addr};
        ent_en = 1'b1;
      end else if (wb_we && (wb_idx == IDX_W'(g))) begin
        ent_d.ready = 1'b0;
        ent_en      = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign table_v[g] = ent_q;
  end

  assign rd_bd = table_v[rd_idx];
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int NUM_BD = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic              ptr_req,
  input  logic [IDX_W-1:0]  ptr_val,
  input  bd_t               bd,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              wb_we,
  output logic [LEN_W-1:0]  lim_out,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              done,
  output logic [IDX_W-1:0]  done_idx,
  output logic [LEN_W-1:0]  done_len,
  output logic              done_frame,
  output logic              done_err,
  output logic              busy
);
  logic              open_q, open_d;
  logic [LEN_W-1:0]  cnt_q, lim_q, left, lim_now, len_out;
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic [IDX_W-1:0]  cur_d;
  logic              busy_d;
  logic              take, opening, wr, close_err, close_ok, closing, last, ptr_ok;

  always_comb begin
    take      = rx_en && rx_valid;
    opening   = take && !open_q && bd.ready && !rx_err;
    wr        = opening || (take && open_q && !rx_err);
    wr_addr   = open_q ? addr_q : bd.addr;
    left      = open_q ? cnt_q : max_len;
    lim_now   = open_q ? lim_q : max_len;
    close_err = take && open_q && rx_err;
    close_ok  = wr && (rx_eof || (left == LEN_W'(1)));
    closing   = close_err || close_ok;
    len_out   = close_err ? (lim_q - cnt_q) : (lim_now - left + LEN_W'(1));
    last      = bd.wrap || (cur_idx == IDX_W'(NUM_BD - 1));
    ptr_ok    = ptr_req && (!rx_en || (!open_q && !take));

    if (closing)     cur_d = last ? base_idx : cur_idx + IDX_W'(1);
    else if (ptr_ok) cur_d = ptr_val;
    else             cur_d = cur_idx;

    if (closing)      open_d = 1'b0;
    else if (opening) open_d = 1'b1;
    else              open_d = open_q;

    if (opening)                                     busy_d = 1'b0;
    else if (take && !open_q && !bd.ready && !rx_err) busy_d = 1'b1;
    else                                             busy_d = busy;

    wb_we   = closing;
    lim_out = lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
      addr_q  <= '0;
      cur_idx <= '0;
      busy    <= 1'b0;
    end else begin
      open_q  <= open_d;
      cur_idx <= cur_d;
      busy    <= busy_d;
      if (opening) lim_q <= max_len;
      if (wr) begin
        cnt_q  <= left - LEN_W'(1);
        addr_q <= wr_addr + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_data   <= '0;
      done       <= 1'b0;
      done_idx   <= '0;
      done_len   <= '0;
      done_frame <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      mem_we <= wr;
      done   <= closing;
      if (wr) begin
        mem_addr <= wr_addr;
        mem_data <= rx_data;
      end
      if (closing) begin
        done_idx   <= cur_idx;
        done_len   <= len_out;
        done_frame <= close_ok && rx_eof;
        done_err   <= close_err;
      end
    end
  end
endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
  import rxbd_pkg::*;
#(
  parameter int               NUM_BD  = 8,
  parameter logic [15:0]      RST_LEN = 16'd64,
  localparam int              IDX_W   = (NUM_BD > 1) ? $clog2(NUM_BD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [LEN_W-1:0]  cfg_wdata,
  input  logic              fifo8_mode,
  input  logic              bd_we,
  input  logic [IDX_W-1:0]  bd_idx,
  input  logic              bd_wrap,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eof,
  input  logic              rx_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              done,
  output logic [IDX_W-1:0]  done_idx,
  output logic [LEN_W-1:0]  done_len,
  output logic              done_frame,
  output logic              done_err,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_ptr
);
  logic [LEN_W-1:0] max_len, lim_w;
  logic [IDX_W-1:0] base_idx, ptr_val;
  logic             ptr_req, wb_we;
  bd_t              cur_bd;

  rxbd_cfg #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .RST_LEN(RST_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo8_mode(fifo8_mode), .max_len(max_len),
    .base_idx(base_idx), .ptr_req(ptr_req), .ptr_val(ptr_val)
  );

  rxbd_bdmem #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_bdmem (
    .clk(clk), .rst_n(rst_n), .host_we(bd_we), .host_idx(bd_idx),
    .host_wrap(bd_wrap), .host_addr(bd_addr), .wb_we(wb_we),
    .wb_idx(cur_ptr), .rd_idx(cur_ptr), .rd_bd(cur_bd)
  );

  rxbd_ctrl #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
    .max_len(max_len), .base_idx(base_idx), .ptr_req(ptr_req),
    .ptr_val(ptr_val), .bd(cur_bd), .cur_idx(cur_ptr), .wb_we(wb_we),
    .lim_out(lim_w), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .done_idx(done_idx),
    .done_len(done_len), .done_frame(done_frame), .done_err(done_err),
    .busy(busy)
  );
endmodule

// File: rtl/rxbd_seq_chk.sv
module rxbd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        done,
  input logic [15:0] done_len,
  input logic        done_frame,
  input logic        done_err,
  input logic        busy,
  input logic [15:0] lim
);
  logic [16:0] seen_q, seen_now;

  assign seen_now = seen_q + 17'(mem_we);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= '0;
    else if (done) seen_q <= '0;
    else           seen_q <= seen_now;
  end

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) && !$past(done) |-> mem_addr == $past(mem_addr) + 16'd1);

  p_len_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> 17'(done_len) == seen_now);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> seen_now <= 17'(lim));

  p_err_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> !mem_we && !done_frame);

  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);
endmodule

bind rxbd_seq rxbd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .done(done), .done_len(done_len), .done_frame(done_frame),
  .done_err(done_err), .busy(busy), .lim(lim_w)
);

// File: tb/rxbd_seq_bench.sv
module rxbd_seq_bench;
  localparam int NB = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, fifo8_mode, bd_we, bd_wrap;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata, bd_addr;
  logic [2:0]  bd_idx;
  logic        rx_en, rx_valid, rx_eof, rx_err;
  logic [7:0]  rx_data;
  logic        mem_we, done, done_frame, done_err, busy;
  logic [15:0] mem_addr, done_len;
  logic [7:0]  mem_data;
  logic [2:0]  done_idx, cur_ptr;

  rxbd_seq #(.NUM_BD(NB)) u_rxbd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo8_mode(fifo8_mode), .bd_we(bd_we),
    .bd_idx(bd_idx), .bd_wrap(bd_wrap), .bd_addr(bd_addr), .rx_en(rx_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .done(done),
    .done_idx(done_idx), .done_len(done_len), .done_frame(done_frame),
    .done_err(done_err), .busy(busy), .cur_ptr(cur_ptr)
  );

  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;
  typedef struct packed { logic [2:0] idx; logic [15:0] len; logic fr; logic er; } dn_t;
  wr_t wq[$];
  dn_t dq[$];
  int  vecs = 0, errs = 0;
  bit  finished = 0;

  int m_len = 64, m_base = 0, m_cur = 0, m_cnt = 0, m_lim = 0, m_addr = 0;
  bit m_open = 0, m_en = 0, m_f8 = 0, m_busy = 0;
  bit m_ready[NB];
  bit m_wrap[NB];
  int m_baddr[NB];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    wr_t e;
    dn_t f;
    if (rst_n) begin
      if (mem_we) begin
        if (wq.size() == 0) chk(1'b0, "R1 unexpected write", mem_addr, 0);
        else begin
          e = wq.pop_front();
          chk(mem_addr == e.a && mem_data == e.d, "R1 write", {mem_addr, mem_data}, e);
        end
      end
      if (done) begin
        if (dq.size() == 0) chk(1'b0, "R12 unexpected done", done_len, 0);
        else begin
          f = dq.pop_front();
          chk({done_idx, done_len, done_frame, done_err} == f, "R12 done",
              {done_idx, done_len, done_frame, done_err}, f);
        end
      end
    end
  end

  task automatic close_m();
    m_ready[m_cur] = 0;
    m_open = 0;
    m_cur = (m_wrap[m_cur] || m_cur == NB - 1) ? m_base : m_cur + 1;
  endtask

  task automatic send(input logic [7:0] d, input bit eof = 0, input bit err = 0);
    rx_valid = 1; rx_data = d; rx_eof = eof; rx_err = err;
    if (m_en) begin
      if (err) begin
        if (m_open) begin
          dq.push_back('{m_cur[2:0], 16'(m_lim - m_cnt), 1'b0, 1'b1});
          close_m();
        end
      end else if (m_open || m_ready[m_cur]) begin
        if (!m_open) begin
          m_open = 1; m_addr = m_baddr[m_cur]; m_cnt = m_len; m_lim = m_len; m_busy = 0;
        end
        wq.push_back('{16'(m_addr), d});
        m_addr++; m_cnt--;
        if (eof || m_cnt == 0) begin
          dq.push_back('{m_cur[2:0], 16'(m_lim - m_cnt), eof, 1'b0});
          close_m();
        end
      end else m_busy = 1;
    end
    @(negedge clk);
    rx_valid = 0; rx_eof = 0; rx_err = 0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    case (sel)
      2'd0: if (v != 0 && (m_f8 || v[1:0] == 0)) m_len = v;
      2'd1: if (v < NB) m_base = v;
      2'd2: if (v < NB && (!m_en || !m_open)) m_cur = v;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_bd(input int i, input logic [15:0] a, input bit w);
    bd_we = 1; bd_idx = 3'(i); bd_addr = a; bd_wrap = w;
    m_ready[i] = 1; m_wrap[i] = w; m_baddr[i] = a;
    @(negedge clk);
    bd_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; fifo8_mode = 0;
    bd_we = 0; bd_idx = 0; bd_wrap = 0; bd_addr = 0;
    rx_en = 0; rx_valid = 0; rx_data = 0; rx_eof = 0; rx_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_we && !done, "R1 reset outputs idle", {mem_we, done}, 0);
    chk(!busy, "R10 reset busy", busy, 0);
    chk(cur_ptr == 0, "R8 reset index", cur_ptr, 0);

    cfg(2'd0, 16'd8);
    load_bd(0, 16'h0100, 0); load_bd(1, 16'h0200, 0);
    load_bd(2, 16'h0300, 0); load_bd(3, 16'h0400, 1);
    rx_en = 1; m_en = 1;
    for (int i = 0; i < 8; i++) send(8'(i));
    chk(done && done_len == 8 && done_idx == 0, "R2 full close at limit", done_len, 8);
    send(8'h08);
    chk(mem_we && mem_addr == 16'h0200, "R3 ninth byte to next buffer", mem_addr, 16'h0200);
    for (int i = 9; i < 20; i++) send(8'(i), i == 19);
    chk(done && done_frame && !done_err && done_len == 4, "R4 early frame end", done_len, 4);
    chk(cur_ptr == 3, "R8 advance", cur_ptr, 3);

    send(8'h40); send(8'h41);
    cfg(2'd0, 16'd4);
    for (int i = 0; i < 6; i++) send(8'(8'h42 + i));
    chk(done && done_len == 8, "R6 limit held for open buffer", done_len, 8);
    chk(cur_ptr == 0, "R8 wrap flag reload", cur_ptr, 0);

    send(8'hAA);
    chk(busy && !mem_we, "R10 dropped byte sets busy", {busy, mem_we}, 2'b10);
    load_bd(0, 16'h0500, 0); load_bd(1, 16'h0600, 0);
    send(8'hB0);
    chk(!busy && mem_we && mem_addr == 16'h0500, "R10 busy clears on open", mem_addr, 16'h0500);
    cfg(2'd2, 16'd5);
    chk(cur_ptr == 0, "R9 index write ignored while open", cur_ptr, 0);
    send(8'hB1, 0, 1);
    chk(done && done_err && !mem_we && done_len == 1, "R5 error close", done_len, 1);
    send(8'hB2, 0, 1);
    chk(!done && !mem_we && cur_ptr == 1, "R5 error ignored when idle", cur_ptr, 1);

    cfg(2'd0, 16'd0); cfg(2'd0, 16'd6);
    for (int i = 0; i < 5; i++) send(8'(8'hC0 + i));
    chk(busy, "R10 busy after full ring", busy, 1);
    fifo8_mode = 1; m_f8 = 1;
    cfg(2'd0, 16'd6);

    rx_en = 0; m_en = 0;
    send(8'hD0); send(8'hD1);
    chk(!mem_we && !done, "R11 disabled receiver ignores bytes", mem_we, 0);
    cfg(2'd2, 16'd6);
    chk(cur_ptr == 6, "R9 index write accepted while disabled", cur_ptr, 6);
    cfg(2'd1, 16'd5);
    load_bd(5, 16'h0900, 0); load_bd(6, 16'h0700, 0); load_bd(7, 16'h0800, 0);
    rx_en = 1; m_en = 1;
    send(8'hE0); send(8'hE1); send(8'hE2, 1);
    chk(done && done_frame && done_len == 3, "R4 frame end length", done_len, 3);
    chk(done_idx == 6, "R12 closed index", done_idx, 6);
    for (int i = 0; i < 6; i++) send(8'(8'hF0 + i));
    chk(done && done_len == 6, "R7 odd limit accepted in byte mode", done_len, 6);
    chk(cur_ptr == 5, "R8 last entry reloads base", cur_ptr, 5);
    send(8'h11); send(8'h12, 1);
    chk(done && done_idx == 5 && done_len == 2, "R12 index after base reload", done_idx, 5);

    repeat (3) @(negedge clk);
    chk(wq.size() == 0 && dq.size() == 0, "R2 all expected results seen",
        wq.size() + dq.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule